// File: doc/BRIEF.md
# Backdoor Key Security Unlock

This block decides whether a secured nonvolatile memory may be opened by a matching key. After reset it captures one security configuration byte. That byte holds a 2-bit key-enable field and a 2-bit security-state field. Software can read both fields but cannot write them.

A key-compare command carries eight key bytes and a launch strobe. The block checks the command against the enable field, the lockout flag and the stored 8-byte key. If all three allow it, the block either opens the part or locks out further attempts.

An unlock lasts only until the next reset, when the configuration byte is loaded again. A single failed compare blocks every later compare until reset. A whole-array erase requested through the debug path is allowed while the part is secured, but it raises a sticky protection-violation flag.

Top module: `key_unlock`

## Requirements
- R1: While `rst_n` is low, every output is 0 except `secured`, which is 1. On the first clock edge after `rst_n` rises, the block captures `cfg_byte`. After that edge, `key_en` is `cfg_byte[7:6]` and `sec_state` is `cfg_byte[1:0]`.
- R2: A compare is accepted only when `cmd_launch` is 1 and `cmd_code` is 0x0C at a clock edge after the configuration has been loaded. A launch with any other code leaves every output unchanged.
- R3: An accepted compare while `key_en` is not 2'b10 sets `access_err` at the next edge. It clears `pass` and `fail` and changes neither `sec_state` nor `locked`.
- R4: An accepted compare passes when `key_en` is 2'b10, `locked` is 0 and all 8 bytes of `cmd_key` equal `stored_key`. It then sets `pass` and makes `sec_state` 2'b10, which drives `secured` to 0.
- R5: A stored key that is all 0x00 bytes or all 0xFF bytes is invalid. A compare against it always fails, even when `cmd_key` equals it.
- R6: An enabled, unlocked compare that does not pass sets `fail` and `locked` at the next edge. `sec_state` is left unchanged.
- R7: Once set, `locked` stays 1 until reset. Every compare accepted while `locked` is 1 gives `access_err` and does not change `sec_state`.
- R8: `secured` is 1 whenever `sec_state` is not 2'b10. A reset discards an earlier unlock and reloads the security state from `cfg_byte`.
- R9: `mass_erase_req` seen at an edge while the configuration is loaded and `secured` is 1 sets `prot_viol`, which stays 1 until reset. While the part is unsecured, the request has no effect on `prot_viol`.
- R10: At most one of `pass`, `fail` and `access_err` is 1 at any time. They keep the result of the last accepted compare until the next accepted compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte | input | 8 | Security configuration byte from nonvolatile storage |
| stored_key | input | 64 | Stored key, byte i in bits 8i+7:8i |
| cmd_code | input | 8 | Command code; 0x0C selects key compare |
| cmd_key | input | 64 | Supplied key bytes |
| cmd_launch | input | 1 | Launch strobe for the command |
| mass_erase_req | input | 1 | Whole-array erase request from the debug path |
| key_en | output | 2 | Key-enable field (read-only) |
| sec_state | output | 2 | Security-state field; 2'b10 means unsecured |
| secured | output | 1 | 1 while the part is secured |
| pass | output | 1 | Last accepted compare matched |
| fail | output | 1 | Last accepted compare mismatched |
| access_err | output | 1 | Last accepted compare was rejected |
| locked | output | 1 | Compares locked out until reset |
| prot_viol | output | 1 | Erase requested while secured |

## Verification
The bench attacks several corner cases, and each one exposes a specific wrong design:

- **Blank stored key.** The bench supplies a key that equals an all-0x00 or all-0xFF stored key. A design that skips the blank check would unlock here.
- **Retry after a failure.** The bench sends the correct key after a failed attempt. A lockout that does not hold would accept it.
- **Launch with a foreign code.** A design that decodes too loosely would produce a result or lock out.
- **Reset after an unlock.** A design that keeps the unlock across reset would stay open.
- **Erase in both states.** The bench requests an erase while secured and while unsecured. A wrong design would miss the violation flag or raise it when the part is open.

Random epochs vary the enable field and mix near-miss keys, which differ from the stored key in a single byte.

// File: rtl/key_unlock.sv
module key_unlock #(
  parameter int KEY_BYTES = 8,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] CMP_CODE = 8'h0C,
  localparam int KW = 8 * KEY_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_byte,
  input  logic [KW-1:0]     stored_key,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [KW-1:0]     cmd_key,
  input  logic              cmd_launch,
  input  logic              mass_erase_req,
  output logic [1:0]        key_en,
  output logic [1:0]        sec_state,
  output logic              secured,
  output logic              pass,
  output logic              fail,
  output logic              access_err,
  output logic              locked,
  output logic              prot_viol
);
  logic [7:0] sec_reg;
  logic loaded;
  logic [KEY_BYTES-1:0] b_eq, b_zero, b_ones;

  for (genvar i = 0; i < KEY_BYTES; i++) begin : g_byte
    assign b_eq[i]   = cmd_key[8*i +: 8] == stored_key[8*i +: 8];
    assign b_zero[i] = stored_key[8*i +: 8] == 8'h00;
    assign b_ones[i] = stored_key[8*i +: 8] == 8'hFF;
  end

  wire key_blank = (&b_zero) | (&b_ones);
  wire key_good  = (&b_eq) & ~key_blank;
  wire accept    = loaded & cmd_launch & (cmd_code == CMP_CODE);
  wire gate_ok   = (key_en == 2'b10) & ~locked;

  assign key_en    = sec_reg[7:6];
  assign sec_state = sec_reg[1:0];
  assign secured   = sec_state != 2'b10;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_reg    <= '0;
      loaded     <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      access_err <= 1'b0;
      locked     <= 1'b0;
      prot_viol  <= 1'b0;
    end else begin
      if (!loaded) begin
        sec_reg <= cfg_byte;
        loaded  <= 1'b1;
      end
      if (accept) begin
        pass       <= gate_ok & key_good;
        fail       <= gate_ok & ~key_good;
        access_err <= ~gate_ok;
        if (gate_ok & key_good) sec_reg[1:0] <= 2'b10;
        if (gate_ok & ~key_good) locked <= 1'b1;
      end
      if (loaded & mass_erase_req & secured) prot_viol <= 1'b1;
    end
  end
endmodule

module key_unlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sec_state,
  input logic       secured,
  input logic       pass,
  input logic       fail,
  input logic       access_err,
  input logic       locked,
  input logic       prot_viol
);
  assert_unlock_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (sec_state == 2'b10 && !secured));
  assert_fail_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> locked);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_reject_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_err) |-> sec_state == $past(sec_state));
  assert_viol_when_secured_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_viol) |-> $past(secured));
  assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_viol |=> prot_viol);
  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass, fail, access_err}));
endmodule

bind key_unlock key_unlock_chk u_chk (.*);

// File: tb/tb_key_unlock.sv
`timescale 1ns/1ps
module tb_key_unlock;
  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_byte = 0, cmd_code = 0;
  logic [63:0] stored_key = 0, cmd_key = 0;
  logic cmd_launch = 0, mass_erase_req = 0;
  logic [1:0] key_en, sec_state;
  logic secured, pass, fail, access_err, locked, prot_viol;

  key_unlock dut (.*);

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;
  logic [7:0] m_cfg;
  logic [1:0] m_sec;
  logic m_loaded, m_pass, m_fail, m_acc, m_lock, m_viol;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit blank(input logic [63:0] k);
    return k == 64'h0 || k == {64{1'b1}};
  endfunction

  task automatic compare_all();
    chk("R1 key_en", {6'b0, key_en}, m_loaded ? {6'b0, m_cfg[7:6]} : 8'h0);
    chk("R4 sec_state", {6'b0, sec_state}, {6'b0, m_sec});
    chk("R8 secured", {7'b0, secured}, {7'b0, m_sec != 2'b10});
    chk("R4 pass", {7'b0, pass}, {7'b0, m_pass});
    chk("R6 fail", {7'b0, fail}, {7'b0, m_fail});
    chk("R3 access_err", {7'b0, access_err}, {7'b0, m_acc});
    chk("R7 locked", {7'b0, locked}, {7'b0, m_lock});
    chk("R9 prot_viol", {7'b0, prot_viol}, {7'b0, m_viol});
    chk("R10 onehot", {7'b0, $countones({pass, fail, access_err}) <= 1}, 8'h1);
  endtask

  task automatic do_reset(input logic [7:0] cfg, input logic [63:0] sk);
    rst_n = 0; cmd_launch = 0; mass_erase_req = 0;
    repeat (2) @(negedge clk);
    m_loaded = 0; m_sec = 0; m_pass = 0; m_fail = 0; m_acc = 0; m_lock = 0; m_viol = 0;
    compare_all();  // R1 reset state
    cfg_byte = cfg; stored_key = sk; m_cfg = cfg;
    rst_n = 1;
  endtask

  task automatic step(input bit l, input logic [7:0] c, input logic [63:0] k, input bit e);
    bit sec_before, ok, good;
    cmd_launch = l; cmd_code = c; cmd_key = k; mass_erase_req = e;
    @(posedge clk);
    sec_before = (m_sec != 2'b10);
    if (!m_loaded) begin
      m_sec = m_cfg[1:0];
    end else begin
      if (l && c == 8'h0C) begin
        ok = (m_cfg[7:6] == 2'b10) && !m_lock;
        good = (k == stored_key) && !blank(stored_key);
        m_pass = ok && good; m_fail = ok && !good; m_acc = !ok;
        if (ok && good) m_sec = 2'b10;
        if (ok && !good) m_lock = 1;
      end
      if (e && sec_before) m_viol = 1;
    end
    m_loaded = 1;
    @(negedge clk);
    cmd_launch = 0; mass_erase_req = 0;
    compare_all();
  endtask

  function automatic logic [63:0] rkey();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [63:0] k;
    void'($urandom(32'd1234));
    k = 64'h0123_4567_89AB_CDEF;

    // R1 load, R4 unlock, R8 reset relocks
    do_reset(8'b1000_0000, k);
    step(0, 0, 0, 0);
    step(1, 8'h0C, k, 0);
    chk("R4 directed unlock", {7'b0, secured}, 8'h0);
    step(0, 0, 0, 1);  // R9 erase while unsecured: no flag
    do_reset(8'b1000_0000, k);
    step(0, 0, 0, 0);
    chk("R8 relocked after reset", {7'b0, secured}, 8'h1);

    // R6/R7 lockout then correct key rejected
    step(1, 8'h0C, k ^ 64'h1, 0);
    step(1, 8'h0C, k, 0);
    chk("R7 correct key after lock", {7'b0, access_err}, 8'h1);

    // R5 blank keys
    do_reset(8'b1000_0011, 64'h0);
    step(0, 0, 0, 0);
    step(1, 8'h0C, 64'h0, 0);
    chk("R5 zero key fails", {7'b0, fail}, 8'h1);
    do_reset(8'b1000_0011, {64{1'b1}});
    step(0, 0, 0, 0);
    step(1, 8'h0C, {64{1'b1}}, 0);
    chk("R5 ones key fails", {7'b0, fail}, 8'h1);

    // R2 other codes, R3 disabled, R9 erase while secured
    do_reset(8'b0100_0001, k);
    step(0, 0, 0, 0);
    step(1, 8'h0D, k, 0);
    chk("R2 other code ignored", {5'b0, pass, fail, access_err}, 8'h0);
    step(1, 8'h0C, k, 0);
    chk("R3 disabled reject", {7'b0, access_err}, 8'h1);
    step(0, 0, 0, 1);
    chk("R9 erase secured", {7'b0, prot_viol}, 8'h1);

    for (int ep = 0; ep < 60; ep++) begin
      logic [7:0] cfg;
      logic [63:0] sk;
      cfg = 8'($urandom);
      if ($urandom % 4 != 0) cfg[7:6] = 2'b10;
      case ($urandom % 8)
        0: sk = 64'h0;
        1: sk = {64{1'b1}};
        default: sk = rkey();
      endcase
      do_reset(cfg, sk);
      step(0, 0, 0, 0);
      for (int n = 0; n < 25; n++) begin
        case ($urandom % 6)
          0, 1: step(1, 8'h0C, sk, $urandom % 4 == 0);
          2: step(1, 8'h0C, sk ^ (64'hFF << (8 * ($urandom % 8))), 0);
          3: step(1, 8'($urandom), rkey(), 0);
          4: step(0, 0, 0, 1);
          default: step(0, 8'h0C, sk, 0);
        endcase
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule